// File: doc/BRIEF.md
# Soft-Mute Gain Ramp Controller

This block sits beside the sample path of a stereo audio converter. It holds the gain code that each channel currently uses. Each code is 8 bits wide: a code X from 1 to 255 stands for 0.5·(X−255) dB, and code 0 is full silence. The block walks each code toward a target, one code at a time. A step happens on every 128th sample strobe, so one 0.5 dB step takes 128 sample periods. The target is the programmed attenuation code. While mute is requested through the active-low pin or the register bit, the target is 0 instead. When common control is selected, the left code serves both channels.

The block also counts samples that are zero on both channels. After 1024 such samples in a row, with detection enabled, it raises an automatic mute. The first non-zero sample clears it. An operation-disable input forces both gain outputs to code 0, which gives bipolar zero downstream. It also raises the analogue-mute flag. Turning the gain code into a multiplier and the audio arithmetic are left to the sample path.

Top module: `gain_ramp_ctrl`

## Requirements
- R1: After reset both gain outputs read 255, the step-interval count is cleared, the analogue-mute flag is low and the zero indicator is high.
- R2: While the mute pin is low or the mute bit is high, each gain code moves one code toward 0 on every 128th sample strobe, and once at 0 it stays there.
- R3: With mute released, each gain code moves one code per 128 strobes toward its programmed attenuation code and then holds that value.
- R4: When the target changes in the middle of a ramp, the ramp continues from the present code in the new direction, never changing by more than one code per step.
- R5: The gain codes change only on the clock edge that follows the strobe which completes a 128-strobe interval. The interval count advances only on strobes.
- R6: With common control high, the right channel ramps toward the left attenuation code. With it low, the right channel ramps toward the right code.
- R7: The analogue-mute flag is high whenever both ramped gain codes are 0.
- R8: With zero detection enabled, 1024 consecutive strobes on which both channel zero flags are high drive the zero indicator low and the analogue-mute flag high. A strobe with either flag low clears this on the next edge. With detection disabled, the zero indicator stays high.
- R9: The automatic zero mute leaves the ramped gain codes unchanged.
- R10: While operation-disable is high, both gain outputs read 0 and the analogue-mute flag is high. The hidden ramp keeps running, so the ramped codes reappear when the input is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_stb | input | 1 | One-cycle pulse per sample period |
| atten_l | input | 8 | Programmed left attenuation code |
| atten_r | input | 8 | Programmed right attenuation code |
| common_sel | input | 1 | Left code drives both channels when high |
| mute_pin_n | input | 1 | Active-low mute request pin |
| mute_bit | input | 1 | Active-high mute request bit |
| op_disable | input | 1 | Forces both outputs to code 0 and raises analogue mute |
| zdet_en | input | 1 | Enables automatic zero mute |
| zero_l | input | 1 | Left sample of this strobe is zero |
| zero_r | input | 1 | Right sample of this strobe is zero |
| gain_l | output | 8 | Current left gain code |
| gain_r | output | 8 | Current right gain code |
| amute | output | 1 | Analogue mute flag |
| zero_n | output | 1 | Active-low infinite-zero indicator |

## Verification
The bench releases mute halfway through a full ramp and checks that the ramp turns around at the code it had reached. A design that restarted the ramp or jumped to the target would show a step larger than one code. It sends strobes sparsely and at random. A step counter that ticked on clocks, or that stepped one strobe early or late, would move the codes at the wrong cycle. Long runs of zero samples are broken exactly at strobe 1023 and then carried past 1024. An off-by-one zero counter, or one that did not clear on a single non-zero sample, would flip the zero indicator at the wrong point. This section also covers operation-disable held through a ramp: a design that froze or cleared the hidden codes would return the wrong values once the input is released.

// File: rtl/gain_ramp_ctrl.sv
module gain_ramp_ctrl #(
  parameter int GW           = 8,
  parameter int STEP_SAMPLES = 128,
  parameter int ZERO_SAMPLES = 1024
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          smp_stb,
  input  logic [GW-1:0] atten_l,
  input  logic [GW-1:0] atten_r,
  input  logic          common_sel,
  input  logic          mute_pin_n,
  input  logic          mute_bit,
  input  logic          op_disable,
  input  logic          zdet_en,
  input  logic          zero_l,
  input  logic          zero_r,
  output logic [GW-1:0] gain_l,
  output logic [GW-1:0] gain_r,
  output logic          amute,
  output logic          zero_n
);

  localparam int SCW = (STEP_SAMPLES > 1) ? $clog2(STEP_SAMPLES) : 1;
  localparam int ZCW = $clog2(ZERO_SAMPLES + 1);
  localparam logic [SCW-1:0] STEP_LAST = SCW'(STEP_SAMPLES - 1);
  localparam logic [ZCW-1:0] ZERO_FULL = ZCW'(ZERO_SAMPLES);

  logic [SCW-1:0] step_cnt;
  logic [ZCW-1:0] zrun;
  logic [GW-1:0]  gl_q, gr_q;
  logic           muted, step_now, automute;
  logic [GW-1:0]  tgt_l, tgt_r;

  function automatic logic [GW-1:0] toward(input logic [GW-1:0] cur, input logic [GW-1:0] tgt);
    if (cur < tgt)      return cur + 1'b1;
    else if (cur > tgt) return cur - 1'b1;
    else                return cur;
  endfunction

  assign muted    = !mute_pin_n || mute_bit;
  assign tgt_l    = muted ? '0 : atten_l;
  assign tgt_r    = muted ? '0 : (common_sel ? atten_l : atten_r);
  assign step_now = smp_stb && (step_cnt == STEP_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_cnt <= '0;
    end else if (smp_stb) begin
      step_cnt <= step_now ? '0 : step_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gl_q <= '1;
      gr_q <= '1;
    end else if (step_now) begin
      gl_q <= toward(gl_q, tgt_l);
      gr_q <= toward(gr_q, tgt_r);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      zrun <= '0;
    end else if (smp_stb) begin
      if (!(zero_l && zero_r)) zrun <= '0;
      else if (zrun != ZERO_FULL) zrun <= zrun + 1'b1;
    end
  end

  assign automute = zdet_en && (zrun == ZERO_FULL);
  assign gain_l   = op_disable ? '0 : gl_q;
  assign gain_r   = op_disable ? '0 : gr_q;
  assign amute    = op_disable || automute || (gl_q == '0 && gr_q == '0);
  assign zero_n   = !automute;

  assert_gain_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (gl_q == $past(gl_q)) || (gl_q == $past(gl_q) + 1'b1) || (gl_q == $past(gl_q) - 1'b1));
  assert_gain_step_r_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (gr_q == $past(gr_q)) || (gr_q == $past(gr_q) + 1'b1) || (gr_q == $past(gr_q) - 1'b1));
  assert_only_on_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_stb |=> ($stable(gl_q) && $stable(gr_q) && $stable(step_cnt)));
  assert_mute_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (muted && gl_q == '0) |=> (gl_q == '0));
  assert_disable_out_R10: assert property (@(posedge clk) disable iff (!rst_n)
    op_disable |-> (gain_l == '0 && gain_r == '0 && amute));
  assert_zero_needs_en_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !zero_n |-> (zdet_en && amute));

endmodule

// File: tb/gain_ramp_ctrl_tb_top.sv
module gain_ramp_ctrl_tb_top;
  localparam int STEP = 128;
  localparam int ZMAX = 1024;

  logic clk = 0, rst_n = 0;
  logic smp_stb = 0, common_sel = 0, mute_pin_n = 1, mute_bit = 0;
  logic op_disable = 0, zdet_en = 0, zero_l = 0, zero_r = 0;
  logic [7:0] atten_l = 8'hFF, atten_r = 8'hFF;
  logic [7:0] gain_l, gain_r;
  logic amute, zero_n;

  int checks = 0, fails = 0;
  int m_cnt = 0, m_zc = 0;
  int m_gl = 255, m_gr = 255;
  string tag = "";
  bit done = 0;

  always #2 clk = ~clk;

  gain_ramp_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .smp_stb(smp_stb), .atten_l(atten_l), .atten_r(atten_r),
    .common_sel(common_sel), .mute_pin_n(mute_pin_n), .mute_bit(mute_bit),
    .op_disable(op_disable), .zdet_en(zdet_en), .zero_l(zero_l), .zero_r(zero_r),
    .gain_l(gain_l), .gain_r(gain_r), .amute(amute), .zero_n(zero_n));

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int toward(input int cur, input int tgt);
    return (cur < tgt) ? cur + 1 : (cur > tgt) ? cur - 1 : cur;
  endfunction

  task automatic model_update();
    bit mu;
    mu = !mute_pin_n || mute_bit;
    if (smp_stb) begin
      if (m_cnt == STEP - 1) begin
        m_cnt = 0;
        m_gl = toward(m_gl, mu ? 0 : int'(atten_l));
        m_gr = toward(m_gr, mu ? 0 : int'(common_sel ? atten_l : atten_r));
      end else m_cnt++;
      if (zero_l && zero_r) begin
        if (m_zc < ZMAX) m_zc++;
      end else m_zc = 0;
    end
  endtask

  task automatic check_outputs();
    bit au, mu;
    string tl, tr;
    au = zdet_en && (m_zc == ZMAX);
    mu = !mute_pin_n || mute_bit;
    tl = (tag != "") ? tag : op_disable ? "R10" : au ? "R9" : mu ? "R2" : "R3";
    tr = (tag != "") ? tag : op_disable ? "R10" : au ? "R9" : common_sel ? "R6" : mu ? "R2" : "R3";
    check(tl, gain_l, op_disable ? 0 : m_gl);
    check(tr, gain_r, op_disable ? 0 : m_gr);
    check(au ? "R8" : op_disable ? "R10" : "R7", amute, (op_disable || au || (m_gl == 0 && m_gr == 0)) ? 1 : 0);
    check("R8", zero_n, au ? 0 : 1);
  endtask

  task automatic run(input int n, input int stb_pct);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      model_update();
      check_outputs();
      smp_stb = (($urandom % 100) < stb_pct);
    end
  endtask

  task automatic run_rand(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      model_update();
      check_outputs();
      smp_stb = ($urandom % 3) != 0;
      if ($urandom % 500 == 0) mute_pin_n = ~mute_pin_n;
      if ($urandom % 700 == 0) mute_bit = ~mute_bit;
      if ($urandom % 400 == 0) common_sel = ~common_sel;
      if ($urandom % 300 == 0) begin atten_l = 8'($urandom); atten_r = 8'($urandom); end
      if ($urandom % 2000 == 0) op_disable = ~op_disable;
      if ($urandom % 1500 == 0) zdet_en = ~zdet_en;
      zero_l = ($urandom % 3000) != 0;
      zero_r = ($urandom % 3000) != 0;
    end
  endtask

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    check("R1", gain_l, 255);
    check("R1", gain_r, 255);
    check("R1", amute, 0);
    check("R1", zero_n, 1);
    rst_n = 1;

    // R2: full mute ramp via pin, strobe every cycle
    atten_l = 8'hC0; atten_r = 8'hA0;
    run(2 * STEP, 100);
    mute_pin_n = 0;
    run(256 * STEP, 100);
    check("R7", amute, 1);
    check("R2", gain_l, 0);

    // R4: release mid ramp, then re-mute via bit mid ramp
    mute_pin_n = 1;
    tag = "R4";
    run(40 * STEP, 100);
    mute_bit = 1;
    run(20 * STEP, 100);
    mute_bit = 0;
    run(300 * STEP, 100);
    tag = "";
    check("R3", gain_l, 8'hC0);
    check("R3", gain_r, 8'hA0);

    // R5: sparse strobes
    tag = "R5";
    atten_l = 8'hB8;
    run(12 * STEP * 4, 25);
    tag = "";

    // R6: common select
    common_sel = 1;
    run(40 * STEP, 100);
    check("R6", gain_r, gain_l);
    common_sel = 0;

    // R10: disable during a ramp
    op_disable = 1;
    mute_bit = 1;
    run(10 * STEP, 100);
    op_disable = 0;
    mute_bit = 0;
    run(10 * STEP, 100);

    // R8: zero run broken at 1023, then carried past 1024
    zdet_en = 1; zero_l = 1; zero_r = 1;
    smp_stb = 0;
    for (int k = 0; k < 1023; k++) begin
      @(negedge clk); model_update(); check_outputs(); smp_stb = 1;
    end
    @(negedge clk); model_update(); check_outputs(); smp_stb = 1; zero_r = 0;
    @(negedge clk); model_update(); check_outputs(); smp_stb = 1; zero_r = 1;
    run(1030, 100);
    check("R8", zero_n, 0);
    check("R9", gain_l, m_gl);
    zero_l = 0;
    run(3, 100);
    check("R8", zero_n, 1);
    zdet_en = 0; zero_l = 1;
    run(1100, 100);
    check("R8", zero_n, 1);

    run_rand(60000);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (190000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule